// File: doc/BRIEF.md
# Time Snapshot Register Access Buffer

This block sits between the byte-level side of a two-wire serial slave and a free-running calendar counter. The counter keeps its own time and date bytes. This block holds a second, user-facing copy of those seven bytes, so the host can read several bytes in a row and get one consistent instant while the counter keeps advancing. The copy is refreshed from the counter only at bus START, at bus STOP, and when the register pointer wraps back to address 00h.

Host writes to the time and date bytes do not reach the counter at once. They land in the copy and are marked pending. When the transfer ends with STOP, all pending bytes go to the counter in a single commit strobe. If the seconds byte is among them, the tick prescaler is told to restart. The rest of the 32-byte map has two parts: 07h–0Fh holds nine alarm and control bytes, which are also brought out for the neighbouring alarm logic, and 10h–1Fh is sixteen bytes of scratch RAM. A single pointer with auto-increment reaches every address.

Top module: `time_snapshot_buf`

## Requirements
- R1: After reset the pointer is 00h, every stored byte and every copy byte reads 00h, no byte is pending, and commit_en, commit_mask and tick_restart are low.
- R2: rd_data always shows the byte at the current pointer. For 00h–06h this is the user copy, not live_time. The copy does not change in a cycle without START, STOP, pointer wrap or a time-byte write.
- R3: On a cycle with bus_start or bus_stop, each copy byte i that is not pending takes live_time[8i+7:8i] at the clock edge. A read in that same cycle still shows the copy as it was before the edge.
- R4: Each cycle with rd_en or wr_en (and no ptr_load) advances the pointer by one after the access. From 1Fh it goes to 00h, and that wrap refreshes the non-pending copy bytes in the same way as R3.
- R5: A write to 00h–06h stores wr_data in the copy and marks the byte pending. A pending byte keeps its written value through START and wrap refreshes until STOP.
- R6: In a bus_stop cycle with at least one pending byte, counting a time-byte write in that same cycle, commit_en is high for that cycle. Bit i of commit_mask marks byte i, and commit_time carries the copy with that write merged in. Outside bus_stop cycles commit_mask is zero. STOP clears every pending mark.
- R7: tick_restart is high exactly in a commit cycle whose commit_mask bit 0 (seconds byte) is set.
- R8: Addresses 07h–0Fh store whatever is written to them and read it back. The byte at address 07h+k also drives cfg_bytes[8k+7:8k].
- R9: Addresses 10h–1Fh are RAM. Each holds any value from 00h to FFh and reads it back.
- R10: ptr_load sets the pointer to ptr_value and takes priority over rd_en and wr_en. A write in the same cycle changes no byte, and neither access moves the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe for a bus START condition |
| bus_stop | input | 1 | One-cycle strobe for a bus STOP condition |
| ptr_load | input | 1 | Load the register pointer |
| ptr_value | input | 5 | Pointer value to load |
| rd_en | input | 1 | Byte read; the pointer advances after it |
| wr_en | input | 1 | Byte write at the pointer; the pointer advances after it |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Byte at the current pointer |
| live_time | input | 56 | Running counter bytes, byte i in bits 8i+7:8i |
| commit_en | output | 1 | Commit pending time bytes to the counter |
| commit_mask | output | 7 | Which time bytes the commit carries |
| commit_time | output | 56 | Byte values for the commit |
| tick_restart | output | 1 | Restart the tick prescaler |
| cfg_bytes | output | 72 | Alarm and control bytes 07h–0Fh |

## Verification
The collisions that matter are a refresh landing in the same cycle as an access. The bench drives a START together with a read and checks that the read returns the old copy while the next read returns the refreshed one. It drives a write to a time byte in the same cycle as STOP and expects that byte both in commit_mask and in commit_time. It also drives a read at 1Fh that wraps while other bytes are pending, and expects the refresh to skip those bytes. A behavioural model in the bench predicts every output on every cycle, and it is checked against a live counter that changes on every clock.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int ADDR_W     = 5;
  localparam int TIME_BYTES = 7;
  localparam int CFG_BYTES  = 9;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/tsb_rst_sync.sv
module tsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/tsb_pointer.sv
module tsb_pointer #(
  parameter int AW = tsb_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          rd,
  input  logic          wr,
  output logic [AW-1:0] ptr,
  output logic          acc,
  output logic          wrap
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  assign acc    = (rd | wr) & ~ld;
  assign wrap   = acc & (ptr_q == '1);
  assign ptr_en = ld | acc;

  always_comb begin
    ptr_d = ptr_q;
    if (ld)       ptr_d = ld_val;
    else if (acc) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/tsb_snapshot.sv
module tsb_snapshot #(
  parameter int AW = tsb_pkg::ADDR_W,
  parameter int NB = tsb_pkg::TIME_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refresh,
  input  logic          stop,
  input  logic          wr_hit,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [8*NB-1:0] live,
  output logic [8*NB-1:0] user_flat,
  output logic          commit_en,
  output logic [NB-1:0] commit_mask,
  output logic [8*NB-1:0] commit_time,
  output logic          tick_restart
);
  import tsb_pkg::byte_t;

  byte_t       user_q [NB];
  byte_t       user_d [NB];
  byte_t       u_m    [NB];
  logic [NB-1:0] user_en;
  logic [NB-1:0] pend_q;
  logic [NB-1:0] pend_d;
  logic [NB-1:0] p_m;
  logic          pend_en;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic hit;
    assign hit        = wr_hit && (wr_idx == AW'(i));
    assign u_m[i]     = hit ? wr_data : user_q[i];
    assign p_m[i]     = pend_q[i] | hit;
    assign user_d[i]  = (refresh && !p_m[i]) ? live[8*i +: 8] : u_m[i];
    assign user_en[i] = hit | refresh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          user_q[i] <= '0;
      else if (user_en[i]) user_q[i] <= user_d[i];
    end

    assign user_flat[8*i +: 8]   = user_q[i];
    assign commit_time[8*i +: 8] = u_m[i];
  end

  assign pend_en = wr_hit | stop;
  assign pend_d  = stop ? '0 : p_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign commit_en    = stop & (|p_m);
  assign commit_mask  = stop ? p_m : '0;
  assign tick_restart = stop & p_m[0];
endmodule

// File: rtl/tsb_store.sv
module tsb_store #(
  parameter int AW   = tsb_pkg::ADDR_W,
  parameter int BASE = tsb_pkg::TIME_BYTES,
  parameter int NB   = (1 << tsb_pkg::ADDR_W) - tsb_pkg::TIME_BYTES,
  parameter int NCFG = tsb_pkg::CFG_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [AW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [7:0]      rd_byte,
  output logic [8*NCFG-1:0] cfg_flat
);
  import tsb_pkg::byte_t;

  byte_t mem_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_hit && (wr_idx == AW'(BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (cell_en) mem_q[i] <= wr_data;
    end

    if (i < NCFG) begin : g_cfg
      assign cfg_flat[8*i +: 8] = mem_q[i];
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_idx == AW'(BASE + i)) rd_byte = mem_q[i];
    end
  end
endmodule

// File: rtl/time_snapshot_buf.sv
module time_snapshot_buf #(
  parameter int AW   = tsb_pkg::ADDR_W,
  parameter int TB   = tsb_pkg::TIME_BYTES,
  parameter int NCFG = tsb_pkg::CFG_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            ptr_load,
  input  logic [AW-1:0]   ptr_value,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic [8*TB-1:0] live_time,
  output logic            commit_en,
  output logic [TB-1:0]   commit_mask,
  output logic [8*TB-1:0] commit_time,
  output logic            tick_restart,
  output logic [8*NCFG-1:0] cfg_bytes
);
  localparam int MAP_BYTES = 1 << AW;
  localparam int STORE_BYTES = MAP_BYTES - TB;
  localparam logic [AW-1:0] TIME_END = AW'(TB);

  logic            rst_q_n;
  logic [AW-1:0]   ptr_q;
  logic            acc;
  logic            wrap;
  logic            is_time;
  logic            wr_time;
  logic            wr_store;
  logic            refresh;
  logic [8*TB-1:0] user_flat;
  logic [7:0]      time_byte;
  logic [7:0]      store_byte;

  tsb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tsb_pointer #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ld     (ptr_load),
    .ld_val (ptr_value),
    .rd     (rd_en),
    .wr     (wr_en),
    .ptr    (ptr_q),
    .acc    (acc),
    .wrap   (wrap)
  );

  assign is_time  = ptr_q < TIME_END;
  assign wr_time  = acc & wr_en & is_time;
  assign wr_store = acc & wr_en & ~is_time;
  assign refresh  = bus_start | bus_stop | wrap;

  tsb_snapshot #(.AW(AW), .NB(TB)) u_snap (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .refresh      (refresh),
    .stop         (bus_stop),
    .wr_hit       (wr_time),
    .wr_idx       (ptr_q),
    .wr_data      (wr_data),
    .live         (live_time),
    .user_flat    (user_flat),
    .commit_en    (commit_en),
    .commit_mask  (commit_mask),
    .commit_time  (commit_time),
    .tick_restart (tick_restart)
  );

  tsb_store #(.AW(AW), .BASE(TB), .NB(STORE_BYTES), .NCFG(NCFG)) u_store (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_hit   (wr_store),
    .wr_idx   (ptr_q),
    .wr_data  (wr_data),
    .rd_idx   (ptr_q),
    .rd_byte  (store_byte),
    .cfg_flat (cfg_bytes)
  );

  always_comb begin
    time_byte = '0;
    for (int i = 0; i < TB; i++) begin
      if (ptr_q == AW'(i)) time_byte = user_flat[8*i +: 8];
    end
  end

  assign rd_data = is_time ? time_byte : store_byte;
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int AW = 5,
  parameter int NB = 7
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          ptr_load,
  input logic [AW-1:0] ptr_value,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] ptr_q,
  input logic          commit_en,
  input logic [NB-1:0] commit_mask,
  input logic          tick_restart,
  input logic [8*NB-1:0] user_flat
);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((rd_en || wr_en) && !ptr_load) |=> (ptr_q == $past(ptr_q) + 1'b1));

  assert_ptr_load_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ptr_load |=> (ptr_q == $past(ptr_value)));

  assert_copy_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(bus_start || bus_stop || wr_en || rd_en || ptr_load) |=> $stable(user_flat));

  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    commit_en |-> bus_stop);

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_stop |-> (commit_mask == '0));

  assert_restart_seconds_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick_restart |-> (commit_en && commit_mask[0]));
endmodule

bind time_snapshot_buf tsb_checker #(.AW(AW), .NB(TB)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .bus_start    (bus_start),
  .bus_stop     (bus_stop),
  .ptr_load     (ptr_load),
  .ptr_value    (ptr_value),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .ptr_q        (ptr_q),
  .commit_en    (commit_en),
  .commit_mask  (commit_mask),
  .tick_restart (tick_restart),
  .user_flat    (user_flat)
);

// File: tb/time_snapshot_buf_tb.sv
module time_snapshot_buf_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_start, bus_stop, ptr_load, rd_en, wr_en;
  logic [4:0]  ptr_value;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [55:0] live_time;
  logic        commit_en;
  logic [6:0]  commit_mask;
  logic [55:0] commit_time;
  logic        tick_restart;
  logic [71:0] cfg_bytes;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  logic [7:0] live_b  [7];
  logic [7:0] m_user  [7];
  logic [6:0] m_pend;
  logic [7:0] m_store [25];
  int         m_ptr;

  time_snapshot_buf u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .live_time(live_time),
    .commit_en(commit_en), .commit_mask(commit_mask), .commit_time(commit_time),
    .tick_restart(tick_restart), .cfg_bytes(cfg_bytes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) live_time[8*i +: 8] = live_b[i];
  end

  task automatic chk(input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit st, input bit ld, input logic [4:0] lv,
                      input bit rd, input bit wr, input logic [7:0] wd);
    logic [7:0]  u2 [7];
    logic [6:0]  p2;
    logic [55:0] ct;
    logic [71:0] cf;
    logic [7:0]  er;
    bit          ce, acc, refr;
    @(negedge clk);
    bus_start = s; bus_stop = st; ptr_load = ld; ptr_value = lv;
    rd_en = rd; wr_en = wr; wr_data = wd;
    #1;
    for (int i = 0; i < 7; i++) u2[i] = m_user[i];
    p2  = m_pend;
    acc = (rd || wr) && !ld;
    if (wr && !ld && m_ptr < 7) begin u2[m_ptr] = wd; p2[m_ptr] = 1'b1; end
    er = (m_ptr < 7) ? m_user[m_ptr] : m_store[m_ptr-7];
    ce = st && (p2 != 0);
    for (int i = 0; i < 7; i++) ct[8*i +: 8] = u2[i];
    for (int i = 0; i < 9; i++) cf[8*i +: 8] = m_store[i];
    chk(cur_req, "rd_data", {64'd0, rd_data}, {64'd0, er});
    chk("R6", "commit_en", {71'd0, commit_en}, {71'd0, ce});
    chk("R6", "commit_mask", {65'd0, commit_mask}, {65'd0, (st ? p2 : 7'd0)});
    if (ce) chk("R6", "commit_time", {16'd0, commit_time}, {16'd0, ct});
    chk("R7", "tick_restart", {71'd0, tick_restart}, {71'd0, (st && p2[0])});
    chk("R8", "cfg_bytes", cfg_bytes, cf);
    refr = s || st || (acc && m_ptr == 31);
    for (int i = 0; i < 7; i++) m_user[i] = (refr && !p2[i]) ? live_b[i] : u2[i];
    m_pend = st ? 7'd0 : p2;
    if (wr && !ld && m_ptr >= 7) m_store[m_ptr-7] = wd;
    if (ld) m_ptr = lv;
    else if (acc) m_ptr = (m_ptr + 1) % 32;
    @(posedge clk);
    #1;
    for (int i = 0; i < 7; i++) begin
      live_b[i] = live_b[i] + 8'(i + 1);
      if (ce && p2[i]) live_b[i] = u2[i];
    end
  endtask

  task automatic idle();       step(0,0,0,5'd0,0,0,8'd0); endtask
  task automatic load(input logic [4:0] a); step(0,0,1,a,0,0,8'd0); endtask
  task automatic rd1();        step(0,0,0,5'd0,1,0,8'd0); endtask
  task automatic wr1(input logic [7:0] d); step(0,0,0,5'd0,0,1,d); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bus_start = 0; bus_stop = 0; ptr_load = 0; ptr_value = 0;
    rd_en = 0; wr_en = 0; wr_data = 0;
    for (int i = 0; i < 7; i++) begin live_b[i] = 8'h30 + 8'(i * 17); m_user[i] = 8'h00; end
    for (int i = 0; i < 25; i++) m_store[i] = 8'h00;
    m_pend = 0; m_ptr = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state, copy stays zero without refresh
    cur_req = "R1";
    idle(); idle();

    // R9: RAM full value range; the last write wraps (R4)
    cur_req = "R9";
    load(5'h10);
    for (int i = 0; i < 16; i++) wr1((i == 0) ? 8'h00 : (i == 15) ? 8'hFF : 8'(8'hA5 ^ (i * 37)));
    load(5'h10);
    for (int i = 0; i < 16; i++) rd1();

    // R8: alarm/control bytes and cfg_bytes
    cur_req = "R8";
    load(5'h07);
    for (int i = 0; i < 9; i++) wr1(8'(8'h11 * (i + 1)));
    load(5'h07);
    for (int i = 0; i < 9; i++) rd1();

    // R2: reads come from the copy while live_time moves
    cur_req = "R2";
    step(1,0,0,5'd0,0,0,8'd0);
    load(5'h00);
    for (int i = 0; i < 7; i++) begin rd1(); idle(); idle(); end

    // R3: START and read in one cycle, then STOP alone
    cur_req = "R3";
    load(5'h00); idle();
    step(1,0,0,5'd0,1,0,8'd0);
    rd1(); idle();
    step(0,1,0,5'd0,0,0,8'd0);
    load(5'h00); rd1();

    // R4: wrap from 1Fh refreshes the copy
    cur_req = "R4";
    load(5'h1F); idle(); idle();
    rd1(); rd1(); rd1();

    // R5: writes land in the copy and survive a repeated START
    cur_req = "R5";
    step(1,0,0,5'd0,0,0,8'd0);
    load(5'h00);
    wr1(8'h45); wr1(8'h59); wr1(8'h23);
    load(5'h00); rd1(); rd1(); rd1();
    step(1,0,0,5'd0,0,0,8'd0);
    load(5'h00); rd1(); rd1(); rd1(); rd1();

    // R6/R7: STOP commits bytes 0..2 with seconds
    cur_req = "R6";
    step(0,1,0,5'd0,0,0,8'd0);
    idle();
    load(5'h00); rd1(); rd1();

    // R6: write in the same cycle as STOP, no seconds byte (R7 low)
    load(5'h03); idle();
    step(0,1,0,5'd0,0,1,8'h06);
    idle(); load(5'h03); rd1();

    // R5: wrap with a pending byte keeps it
    cur_req = "R5";
    load(5'h06); wr1(8'h99);
    load(5'h1F); rd1();
    load(5'h06); rd1();
    cur_req = "R7";
    load(5'h00); wr1(8'h12);
    step(0,1,0,5'd0,0,0,8'd0);
    idle();

    // R10: ptr_load wins over rd_en and wr_en
    cur_req = "R10";
    step(0,0,1,5'h05,1,0,8'd0);
    idle();
    load(5'h12); idle();
    step(0,0,1,5'h10,0,1,8'h55);
    idle(); rd1(); rd1();
    step(0,0,1,5'h08,0,1,8'h77);
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule